// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block decodes the write-cycle command protocol of an asynchronous parallel NOR flash on behalf of a behavioural storage array. A host issues single-cycle read and write strobes with a byte address and data. The sequencer checks address-qualified unlock cycles and chooses what a read returns: array data, a toggling status byte, identification words, or a query table held in a small ROM.

Word programming can only clear bits, because new data is ANDed into the stored word. Chip and sector erase are passed as one-cycle requests to a separate erase-timing block. While that block works, the sequencer fills the affected words with ones at one word per cycle. It returns to array reads once the timing block reports completion and the fill has finished.

Identification and query modes fall back to array reads on their own after a fixed number of consecutive reads. An unlock-bypass state lets a host program or enter identification with a single command write, without the unlock pair.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset `rd_valid`, `rdata`, `ers_sector_req` and `ers_chip_req` are all 0, the block reads array data, and bypass is off.
- R2: A read strobe is answered in the next cycle with `rd_valid` high for exactly one cycle, carrying the data of the mode in force when the strobe was taken. The read port has no back-pressure, so the host must accept every answer.
- R3: An unlock pair is data 0xAA at word offset `UNLOCK_A0` followed by data 0x55 at `UNLOCK_A1`. Commands compare the low byte of `wdata`. Offsets compare the low 11 bits of the word offset, which is the byte address shifted right by 1 for a 16-bit device and by 0 for an 8-bit device. Any mismatch returns to array reads.
- R4: After an unlock pair, the third write must target `UNLOCK_A0` unless bypass is on. On that write, 0x80 starts erase setup, 0x90 enters identification, 0xA0 arms a program, and 0x20 turns bypass on and returns to array reads. Any other data or address returns to array reads.
- R5: The write that follows an armed program stores old AND new into the addressed word and holds a busy phase of `PROG_CYCLES` cycles. During that phase a read returns status with DQ7 equal to the inverse of bit 7 of the written value, and DQ2 equal to 0.
- R6: After 0x80, a second unlock pair is required. Then 0x10 at `UNLOCK_A0` raises `ers_chip_req` and sets every word to ones. 0x30 at any address raises `ers_sector_req`, drives `ers_addr` to the sector's base byte address and sets that sector's `SECT_WORDS` words to ones. Each request lasts one cycle, in the cycle after the command write. 0x10 at any other address, or any other data, raises no request and returns to array reads.
- R7: During an erase, a status read returns DQ7=0 and toggles both DQ6 (bit 6) and DQ2 (bit 2). In a program busy phase only DQ6 toggles. Both toggles start at 0 when a busy phase begins and flip after each status read, and every other bit reads 0. Array reads resume once `ers_done` has been seen and the fill is complete.
- R8: Data 0xF0 returns to array reads, except in three cases. During a program busy phase or an erase it is ignored. On an armed program it is stored as program data. In query-from-identification mode it returns to identification.
- R9: In identification mode the low 8 bits of the word offset select the result: 0 reads `ID0`, 1 reads `ID1`, 2 (protection) reads 0x00, and any other offset reads array data.
- R10: Data 0x98 at word offset 0x55 enters query mode from array reads, or query-from-identification mode from identification. A query read returns the ROM word for offsets below `CFI_WORDS` and 0 above; words 0x10, 0x11 and 0x12 hold 0x51, 0x52 and 0x59. Any other write in either query mode returns to array reads.
- R11: With bypass on, a single write of 0xA0 at any address arms a program, and a single write of 0x90 enters identification. Writing 0x00 while in identification turns bypass off and returns to array reads.
- R12: In identification or either query mode, reads are counted from the last write. The read that finds `LAZY_LIMIT` (42) reads already counted returns array data and leaves the block in array reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Single-cycle read strobe |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8*DEV_BYTES | Write data or command |
| rd_valid | output | 1 | Read answer valid, one cycle after `rd_en` |
| rdata | output | 8*DEV_BYTES | Read answer |
| ers_sector_req | output | 1 | One-cycle sector erase request |
| ers_chip_req | output | 1 | One-cycle chip erase request |
| ers_addr | output | ADDR_W | Base byte address of the sector to erase |
| ers_done | input | 1 | Erase-timing block reports completion |

## Verification
Every read answer is registered and appears one cycle after its strobe. Mode changes made by a write act on the next strobe. Erase requests appear in the cycle after the command write. A program busy phase ends `PROG_CYCLES` cycles after its data write, and a fill takes one cycle per word. The driver changes inputs on falling edges, and the monitor pops the expected value for each answer at the falling edge that follows the registering edge. Request pins are sampled directly after the command write's edge, and array contents after an operation are read only once the busy phase or fill window has clearly elapsed.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  typedef enum logic [3:0] {
    M_ARRAY, M_UNLK1, M_UNLK2, M_EU0, M_EU1, M_ECMD,
    M_PWAIT, M_PBUSY, M_EBUSY, M_AUTO, M_CFI, M_ACFI
  } mode_e;

  localparam logic [7:0] C_KEY_A    = 8'hAA;
  localparam logic [7:0] C_KEY_B    = 8'h55;
  localparam logic [7:0] C_ERS_SET  = 8'h80;
  localparam logic [7:0] C_IDENT    = 8'h90;
  localparam logic [7:0] C_PROG     = 8'hA0;
  localparam logic [7:0] C_BYP_ON   = 8'h20;
  localparam logic [7:0] C_BYP_OFF  = 8'h00;
  localparam logic [7:0] C_CHIP     = 8'h10;
  localparam logic [7:0] C_SECT     = 8'h30;
  localparam logic [7:0] C_RESET    = 8'hF0;
  localparam logic [7:0] C_QUERY    = 8'h98;
  localparam logic [10:0] QUERY_OFS = 11'h055;
endpackage

// File: rtl/nor_cfi_rom.sv
module nor_cfi_rom #(
  parameter int DW         = 16,
  parameter int IDX_W      = 6,
  parameter int WA_W       = 11,
  parameter int DEV_BYTES  = 2,
  parameter int SECT_WORDS = 256
) (
  input  logic [IDX_W-1:0] idx,
  output logic [DW-1:0]    q
);
  localparam int SHIFT     = (DEV_BYTES == 2) ? 1 : 0;
  localparam int SIZE_LOG2 = WA_W + SHIFT;
  localparam int NBLK      = (1 << WA_W) / SECT_WORDS;
  localparam int SBYTES    = SECT_WORDS * DEV_BYTES;

  logic [7:0] i8;
  logic [7:0] v;
  assign i8 = 8'(idx);

  always_comb begin
    case (i8)
      8'h10: v = 8'h51;
      8'h11: v = 8'h52;
      8'h12: v = 8'h59;
      8'h13: v = 8'h02;
      8'h1B: v = 8'h27;
      8'h1C: v = 8'h36;
      8'h1F: v = 8'h07;
      8'h21: v = 8'h09;
      8'h22: v = 8'h0C;
      8'h23: v = 8'h01;
      8'h25: v = 8'h0A;
      8'h26: v = 8'h0D;
      8'h27: v = 8'(SIZE_LOG2);
      8'h28: v = (DEV_BYTES == 2) ? 8'h02 : 8'h00;
      8'h2C: v = 8'h01;
      8'h2D: v = 8'(NBLK - 1);
      8'h2E: v = 8'((NBLK - 1) >> 8);
      8'h2F: v = 8'(SBYTES >> 8);
      8'h30: v = 8'(SBYTES >> 16);
      default: v = 8'h00;
    endcase
    q = '0;
    q[7:0] = v;
  end
endmodule

// File: rtl/nor_status_gen.sv
module nor_status_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       rd_pulse,
  input  logic       is_erase,
  input  logic       prog_b7,
  output logic [7:0] status
);
  logic tog6, tog2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog6 <= 1'b0;
      tog2 <= 1'b0;
    end else if (clear) begin
      tog6 <= 1'b0;
      tog2 <= 1'b0;
    end else if (rd_pulse) begin
      tog6 <= ~tog6;
      if (is_erase) tog2 <= ~tog2;
    end
  end

  assign status = {(is_erase ? 1'b0 : ~prog_b7), tog6, 3'b000,
                   (is_erase ? tog2 : 1'b0), 2'b00};
endmodule

// File: rtl/nor_word_array.sv
module nor_word_array #(
  parameter int DW   = 16,
  parameter int WA_W = 11
) (
  input  logic            clk,
  input  logic            and_we,
  input  logic [WA_W-1:0] and_addr,
  input  logic [DW-1:0]   and_data,
  input  logic            set_we,
  input  logic [WA_W-1:0] set_addr,
  input  logic [WA_W-1:0] rd_addr,
  output logic [DW-1:0]   rd_data
);
  localparam int WORDS = 1 << WA_W;
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (and_we)      mem[and_addr] <= mem[and_addr] & and_data;
    else if (set_we) mem[set_addr] <= '1;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int          DEV_BYTES   = 2,
  parameter int          ADDR_W      = 12,
  parameter int          SECT_WORDS  = 256,
  parameter int          PROG_CYCLES = 4,
  parameter int          LAZY_LIMIT  = 42,
  parameter int          CFI_WORDS   = 64,
  parameter logic [10:0] UNLOCK_A0   = 11'h555,
  parameter logic [10:0] UNLOCK_A1   = 11'h2AA,
  parameter logic [15:0] ID0         = 16'h0001,
  parameter logic [15:0] ID1         = 16'h227E,
  localparam int         DW          = 8 * DEV_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic              rd_valid,
  output logic [DW-1:0]     rdata,
  output logic              ers_sector_req,
  output logic              ers_chip_req,
  output logic [ADDR_W-1:0] ers_addr,
  input  logic              ers_done
);
  localparam int SHIFT     = (DEV_BYTES == 2) ? 1 : 0;
  localparam int WA_W      = ADDR_W - SHIFT;
  localparam int WORDS     = 1 << WA_W;
  localparam int SECT_BITS = $clog2(SECT_WORDS);
  localparam int PC_W      = $clog2(PROG_CYCLES + 1);
  localparam int LC_W      = $clog2(LAZY_LIMIT + 1);
  localparam int CI_W      = $clog2(CFI_WORDS);
  localparam logic [ADDR_W-1:0] SECT_MASK = {ADDR_W{1'b1}} << (SECT_BITS + SHIFT);

  mode_e           mode;
  logic            bypass;
  logic [LC_W-1:0] lazy_cnt;
  logic [PC_W-1:0] pcnt;
  logic [WA_W-1:0] sweep_ptr;
  logic [WA_W:0]   sweep_left;
  logic            done_seen;
  logic            prog_b7;

  logic [WA_W-1:0] woff;
  logic [10:0]     a11;
  logic [7:0]      cmd;
  logic            hit_u0, hit_u1, hit_q;
  logic            idle_na, lazy_hit, rst_cmd, chip_go, sect_go, pgm_go;
  logic [DW-1:0]   arr_q, rom_q, rnext;
  logic [7:0]      status;
  mode_e           rd_mode;

  assign woff = addr[ADDR_W-1:SHIFT];

  generate
    if (WA_W >= 11) begin : g_cmp_wide
      assign a11 = woff[10:0];
    end else begin : g_cmp_narrow
      assign a11 = {{(11 - WA_W){1'b0}}, woff};
    end
  endgenerate

  assign cmd    = wdata[7:0];
  assign hit_u0 = (a11 == UNLOCK_A0);
  assign hit_u1 = (a11 == UNLOCK_A1);
  assign hit_q  = (a11 == QUERY_OFS);

  assign idle_na  = (mode == M_AUTO) || (mode == M_CFI) || (mode == M_ACFI);
  assign lazy_hit = rd_en && !wr_en && idle_na && (lazy_cnt == LC_W'(LAZY_LIMIT));
  assign rst_cmd  = wr_en && (cmd == C_RESET) &&
                    !((mode == M_PWAIT) || (mode == M_PBUSY) || (mode == M_EBUSY));
  assign chip_go  = wr_en && (mode == M_ECMD) && (cmd == C_CHIP) && hit_u0;
  assign sect_go  = wr_en && (mode == M_ECMD) && (cmd == C_SECT);
  assign pgm_go   = wr_en && (mode == M_PWAIT);

  nor_word_array #(.DW(DW), .WA_W(WA_W)) u_array (
    .clk      (clk),
    .and_we   (pgm_go),
    .and_addr (woff),
    .and_data (wdata),
    .set_we   ((mode == M_EBUSY) && (sweep_left != '0)),
    .set_addr (sweep_ptr),
    .rd_addr  (woff),
    .rd_data  (arr_q)
  );

  nor_cfi_rom #(.DW(DW), .IDX_W(CI_W), .WA_W(WA_W), .DEV_BYTES(DEV_BYTES),
                .SECT_WORDS(SECT_WORDS)) u_rom (
    .idx (woff[CI_W-1:0]),
    .q   (rom_q)
  );

  nor_status_gen u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (pgm_go || chip_go || sect_go),
    .rd_pulse (rd_en && ((mode == M_PBUSY) || (mode == M_EBUSY))),
    .is_erase (mode == M_EBUSY),
    .prog_b7  (prog_b7),
    .status   (status)
  );

  always_comb begin
    rd_mode = lazy_hit ? M_ARRAY : mode;
    rnext   = arr_q;
    case (rd_mode)
      M_PBUSY, M_EBUSY: begin
        rnext = '0;
        rnext[7:0] = status;
      end
      M_AUTO: begin
        if (woff[7:0] == 8'd0)      rnext = ID0[DW-1:0];
        else if (woff[7:0] == 8'd1) rnext = ID1[DW-1:0];
        else if (woff[7:0] == 8'd2) rnext = '0;
      end
      M_CFI, M_ACFI: rnext = (32'(woff) < CFI_WORDS) ? rom_q : '0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode           <= M_ARRAY;
      bypass         <= 1'b0;
      lazy_cnt       <= '0;
      pcnt           <= '0;
      sweep_ptr      <= '0;
      sweep_left     <= '0;
      done_seen      <= 1'b0;
      prog_b7        <= 1'b0;
      ers_sector_req <= 1'b0;
      ers_chip_req   <= 1'b0;
      ers_addr       <= '0;
      rd_valid       <= 1'b0;
      rdata          <= '0;
    end else begin
      ers_sector_req <= 1'b0;
      ers_chip_req   <= 1'b0;
      rd_valid       <= rd_en;
      if (rd_en) rdata <= rnext;

      if (wr_en || !idle_na) lazy_cnt <= '0;
      else if (rd_en && lazy_cnt != LC_W'(LAZY_LIMIT)) lazy_cnt <= lazy_cnt + 1'b1;

      if (lazy_hit) begin
        mode <= M_ARRAY;
      end else if (rst_cmd) begin
        mode <= (mode == M_ACFI) ? M_AUTO : M_ARRAY;
      end else if (wr_en) begin
        case (mode)
          M_ARRAY: begin
            if (hit_q && cmd == C_QUERY)        mode <= M_CFI;
            else if (hit_u0 && cmd == C_KEY_A)  mode <= M_UNLK1;
            else if (bypass && cmd == C_PROG)   mode <= M_PWAIT;
            else if (bypass && cmd == C_IDENT)  mode <= M_AUTO;
          end
          M_UNLK1: mode <= (hit_u1 && cmd == C_KEY_B) ? M_UNLK2 : M_ARRAY;
          M_UNLK2: begin
            if (!bypass && !hit_u0) mode <= M_ARRAY;
            else begin
              case (cmd)
                C_ERS_SET: mode <= M_EU0;
                C_IDENT:   mode <= M_AUTO;
                C_PROG:    mode <= M_PWAIT;
                C_BYP_ON: begin
                  bypass <= 1'b1;
                  mode   <= M_ARRAY;
                end
                default:   mode <= M_ARRAY;
              endcase
            end
          end
          M_EU0: mode <= (hit_u0 && cmd == C_KEY_A) ? M_EU1 : M_ARRAY;
          M_EU1: mode <= (hit_u1 && cmd == C_KEY_B) ? M_ECMD : M_ARRAY;
          M_ECMD: begin
            if (chip_go) begin
              ers_chip_req <= 1'b1;
              sweep_ptr    <= '0;
              sweep_left   <= (WA_W + 1)'(WORDS);
              done_seen    <= 1'b0;
              mode         <= M_EBUSY;
            end else if (sect_go) begin
              ers_sector_req <= 1'b1;
              ers_addr       <= addr & SECT_MASK;
              sweep_ptr      <= {woff[WA_W-1:SECT_BITS], {SECT_BITS{1'b0}}};
              sweep_left     <= (WA_W + 1)'(SECT_WORDS);
              done_seen      <= 1'b0;
              mode           <= M_EBUSY;
            end else begin
              mode <= M_ARRAY;
            end
          end
          M_PWAIT: begin
            prog_b7 <= wdata[7];
            pcnt    <= '0;
            mode    <= M_PBUSY;
          end
          M_AUTO: begin
            if (hit_q && cmd == C_QUERY) mode <= M_ACFI;
            else begin
              if (bypass && cmd == C_BYP_OFF) bypass <= 1'b0;
              mode <= M_ARRAY;
            end
          end
          M_CFI, M_ACFI: mode <= M_ARRAY;
          default: ;
        endcase
      end

      if (mode == M_PBUSY) begin
        pcnt <= pcnt + 1'b1;
        if (pcnt == PC_W'(PROG_CYCLES - 1)) mode <= M_ARRAY;
      end

      if (mode == M_EBUSY) begin
        done_seen <= done_seen | ers_done;
        if (sweep_left != '0) begin
          sweep_ptr  <= sweep_ptr + 1'b1;
          sweep_left <= sweep_left - 1'b1;
        end else if (done_seen) begin
          mode <= M_ARRAY;
        end
      end
    end
  end
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int DEV_BYTES  = 2,
  parameter int ADDR_W     = 12,
  parameter int SECT_WORDS = 256
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rd_en,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        addr,
  input logic [8*DEV_BYTES-1:0]   wdata,
  input logic                     rd_valid,
  input logic                     ers_sector_req,
  input logic                     ers_chip_req,
  input logic [ADDR_W-1:0]        ers_addr
);
  localparam int SHIFT = (DEV_BYTES == 2) ? 1 : 0;
  localparam logic [ADDR_W-1:0] LOW_MASK =
    ~({ADDR_W{1'b1}} << ($clog2(SECT_WORDS) + SHIFT));

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rd_valid && !ers_sector_req && !ers_chip_req);

  a_r2_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  a_r2_no_spurious_answer: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  a_r6_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ers_sector_req, ers_chip_req}));

  a_r6_chip_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ers_chip_req |-> $past(wr_en) && ($past(wdata[7:0]) == 8'h10));

  a_r6_sect_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ers_sector_req |-> $past(wr_en) && ($past(wdata[7:0]) == 8'h30));

  a_r6_chip_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ers_chip_req |=> !ers_chip_req);

  a_r6_sect_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ers_sector_req |=> !ers_sector_req);

  a_r6_sect_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    ers_sector_req |-> ((ers_addr & LOW_MASK) == '0));
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(
  .DEV_BYTES(DEV_BYTES), .ADDR_W(ADDR_W), .SECT_WORDS(SECT_WORDS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .rd_valid(rd_valid), .ers_sector_req(ers_sector_req),
  .ers_chip_req(ers_chip_req), .ers_addr(ers_addr)
);

// File: tb/tb_nor_cmd_seq.sv
module tb_nor_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        rd_valid;
  logic [15:0] rdata;
  logic        ers_sector_req, ers_chip_req;
  logic [11:0] ers_addr;
  logic        ers_done = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  localparam logic [11:0] BU0 = 12'hAAA;
  localparam logic [11:0] BU1 = 12'h554;
  localparam logic [11:0] BQ  = 12'h0AA;

  always #10 clk = ~clk;

  nor_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_valid(rd_valid), .rdata(rdata),
    .ers_sector_req(ers_sector_req), .ers_chip_req(ers_chip_req),
    .ers_addr(ers_addr), .ers_done(ers_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected answer", rdata, 0);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rdata == e, t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic unlock();
    wr(BU0, 16'h00AA);
    wr(BU1, 16'h0055);
  endtask

  task automatic command(input logic [7:0] c);
    unlock();
    wr(BU0, {8'h00, c});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_ers(input int n);
    idle(5);
    @(negedge clk); ers_done = 1'b1;
    @(negedge clk); ers_done = 1'b0;
    idle(n);
  endtask

  initial begin
    #(20 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    chk(rdata == 16'h0, "R1 rdata", rdata, 0);
    chk(!ers_chip_req && !ers_sector_req, "R1 requests", {ers_chip_req, ers_sector_req}, 0);

    // R6/R7/R8: chip erase with status toggles and an ignored 0xF0
    command(8'h80); unlock(); wr(BU0, 16'h0010);
    chk(ers_chip_req == 1'b1, "R6 chip req", ers_chip_req, 1);
    chk(ers_sector_req == 1'b0, "R6 no sector req", ers_sector_req, 0);
    rd(12'h000, 16'h0000, "R7 erase status 1");
    rd(12'h000, 16'h0044, "R7 erase status 2");
    wr(12'h000, 16'h00F0);
    rd(12'h000, 16'h0000, "R8 reset ignored in erase");
    finish_ers(2100);
    rd(12'h000, 16'hFFFF, "R6 chip filled low");
    rd(12'hFFE, 16'hFFFF, "R6 chip filled high");

    // R5: program with status, then AND
    command(8'hA0); wr(12'h026, 16'hA5A5);
    rd(12'h026, 16'h0000, "R5 program status 1");
    rd(12'h026, 16'h0040, "R5 program status 2");
    idle(6);
    rd(12'h026, 16'hA5A5, "R5 programmed");
    command(8'hA0); wr(12'h026, 16'h0FF0);
    idle(6);
    rd(12'h026, 16'h05A0, "R5 AND only");

    // R6: sector erase
    command(8'hA0); wr(12'h200, 16'h1234); idle(6);
    command(8'hA0); wr(12'h600, 16'h5678); idle(6);
    command(8'h80); unlock(); wr(12'h204, 16'h0030);
    chk(ers_sector_req == 1'b1, "R6 sector req", ers_sector_req, 1);
    chk(ers_addr == 12'h200, "R6 sector base", ers_addr, 12'h200);
    rd(12'h000, 16'h0000, "R7 sector status");
    finish_ers(300);
    rd(12'h200, 16'hFFFF, "R6 sector first word");
    rd(12'h3FE, 16'hFFFF, "R6 sector last word");
    rd(12'h600, 16'h5678, "R6 other sector kept");
    rd(12'h026, 16'h05A0, "R6 sector 0 kept");

    // R6: chip erase at wrong address rejected
    command(8'h80); unlock(); wr(12'h000, 16'h0010);
    chk(ers_chip_req == 1'b0, "R6 chip rejected", ers_chip_req, 0);
    rd(12'h026, 16'h05A0, "R6 back to array");

    // R3: bad second unlock
    wr(BU0, 16'h00AA); wr(12'h100, 16'h0055); wr(BU0, 16'h0090);
    rd(12'h000, 16'hFFFF, "R3 unlock mismatch");
    // R4: third cycle wrong address, unknown command
    unlock(); wr(12'h000, 16'h0090);
    rd(12'h000, 16'hFFFF, "R4 third cycle address");
    command(8'h77);
    rd(12'h000, 16'hFFFF, "R4 unknown command");

    // R9: identification
    command(8'h90);
    rd(12'h000, 16'h0001, "R9 ID0");
    rd(12'h002, 16'h227E, "R9 ID1");
    rd(12'h004, 16'h0000, "R9 protection");
    rd(12'h026, 16'h05A0, "R9 other offset");
    // R10/R8: query from identification
    wr(BQ, 16'h0098);
    rd(12'h020, 16'h0051, "R10 Q");
    rd(12'h024, 16'h0059, "R10 Y");
    rd(12'h0C0, 16'h0000, "R10 beyond table");
    wr(12'h000, 16'h00F0);
    rd(12'h000, 16'h0001, "R8 back to identification");
    wr(12'h000, 16'h00F0);
    rd(12'h000, 16'hFFFF, "R8 back to array");

    // R12: lazy return from query mode
    wr(BQ, 16'h0098);
    for (int i = 0; i < 42; i++) rd(12'h022, 16'h0052, "R12 query hold");
    rd(12'h026, 16'h05A0, "R12 lazy array read");
    rd(12'h020, 16'hFFFF, "R12 stays array");

    // R11: bypass
    command(8'h20);
    wr(12'h000, 16'h00A0); wr(12'h040, 16'h0F0F); idle(6);
    rd(12'h040, 16'h0F0F, "R11 bypass program");
    wr(12'h000, 16'h0090);
    rd(12'h000, 16'h0001, "R11 bypass identification");
    wr(12'h000, 16'h0000);
    rd(12'h000, 16'hFFFF, "R11 bypass exit");
    wr(12'h000, 16'h00A0); wr(12'h040, 16'h0000); idle(6);
    rd(12'h040, 16'h0F0F, "R11 bypass off");

    // R8: 0xF0 as program data
    command(8'hA0); wr(12'h060, 16'h00F0); idle(6);
    rd(12'h060, 16'h00F0, "R8 F0 programmed");

    idle(4);
    chk(exp_q.size() == 0, "R2 answers missing", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule